// File: doc/BRIEF.md
# I2C Second Slave Address Match Flag

This block listens to an I2C bus as a slave receiver and raises a sticky status flag when the first byte after a START carries a programmable second 7-bit slave address. The raw SCL and SDA samples are brought into the clock domain through a two-flop synchronizer. START is detected as SDA falling while SCL is high. SDA is then sampled on each of the next eight SCL rising edges, most significant bit first. The seven address bits are compared with the programmed value, and the eighth bit (read/write) takes no part in the comparison.

The flag can be set only in slave receive mode and only while the format-select input for the second address is 0. Three separate paths clear it:
- a new START on the bus;
- master mode, which holds the flag at 0;
- a software handshake, in which the flag must be read as 1 and a 0 is then written.

Each set event also produces a one-cycle match pulse. The register-access port is a plain read strobe and write strobe with a one-bit write value. Read data is the flag output itself. There is no data stream at the block's edge, so no valid/ready handshake exists and back-pressure does not apply.

Top module: `i2c_altaddr_match`

## Requirements
- R1: After the first eight SCL rising edges that follow a START, the flag goes to 1 and match_pulse is high for exactly one cycle (the same cycle the flag rises) when all of these hold: the first seven sampled bits (MSB first) equal alt_addr, is_master=0 and is_transmit=0. The eighth bit (read/write) is ignored. A mismatch leaves the flag at 0.
- R2: When alt_fmt_sel=1 on the completing edge, no set occurs and no pulse is produced.
- R3: A START clears the flag one cycle after it is detected. START is SDA going 1→0 while SCL stays 1, both taken after synchronization. A START also restarts byte capture, including in the middle of a byte.
- R4: While is_master=1 the flag is cleared and held at 0, and no match can set it.
- R5: The flag clears when reg_wr=1 with reg_wdata=0, provided an earlier reg_rd cycle saw flag=1 and no write has occurred since that read.
- R6: A write with reg_wdata=1 has no effect on the flag. A write of 0 that is not preceded by a read returning 1 also has no effect on the flag.
- R7: If a set event and a software clear occur in the same cycle, the flag ends at 1.
- R8: Only the first byte after a START is compared. Later bytes without a new START never set the flag.
- R9: When is_transmit=1 on the completing edge, no set occurs.
- R10: After reset, flag and match_pulse are 0. A bus edge reaches the flag logic through the 2 synchronizer stages, so the flag rises 2 clock cycles after the cycle in which the last address clock edge is first sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL sample |
| sda_in | input | 1 | Raw SDA sample |
| is_master | input | 1 | 1 = master mode |
| is_transmit | input | 1 | 1 = transmit mode, 0 = receive |
| alt_addr | input | 7 | Second slave address |
| alt_fmt_sel | input | 1 | Format select; 1 disables setting |
| reg_rd | input | 1 | Software read strobe of the flag |
| reg_wr | input | 1 | Software write strobe |
| reg_wdata | input | 1 | Value written to the flag |
| flag | output | 1 | Second-address match flag (also the read data) |
| match_pulse | output | 1 | One-cycle pulse on each set event |

## Verification
A wrong bit counter or shift register shows up at the ports as a flag that rises on the wrong byte or not at all. The error appears two cycles after the eighth SCL rise, and the bench's per-cycle reference model catches it on that cycle. A stale software-clear arm shows up as a write of 0 that clears the flag when it should not, or fails to clear it when it should, and is seen one cycle after the write. A wrong START detector shows up as a flag that survives a START, and is seen one cycle after the third synchronized sample.

// File: rtl/i2c_altaddr_pkg.sv
package i2c_altaddr_pkg;
  typedef struct packed {
    logic start;     // SDA fell while SCL high
    logic scl_rise;  // SCL rising edge
    logic sda;       // synchronized SDA level
  } bus_evt_t;
endpackage

// File: rtl/altaddr_sync.sv
module altaddr_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;                 // idle bus is high
      else        chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/altaddr_bus_events.sv
module altaddr_bus_events
  import i2c_altaddr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_s,
  input  logic     sda_s,
  output bus_evt_t evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_comb begin
    evt.start    = scl_s & scl_q & sda_q & ~sda_s;
    evt.scl_rise = scl_s & ~scl_q;
    evt.sda      = sda_s;
  end
endmodule

// File: rtl/altaddr_frame_capture.sv
module altaddr_frame_capture
  import i2c_altaddr_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_evt_t          evt,
  output logic              frame_done,
  output logic [ADDR_W-1:0] addr_bits
);
  localparam int FRAME_BITS = ADDR_W + 1;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

  logic              active;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] shreg;

  // Completing edge: the address bits are already shifted in, the
  // incoming bit is the read/write bit and is not kept.
  assign frame_done = evt.scl_rise & active & (cnt == LAST);
  assign addr_bits  = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      shreg  <= '0;
    end else if (evt.start) begin
      active <= 1'b1;
      cnt    <= '0;
      shreg  <= '0;
    end else if (evt.scl_rise && active) begin
      if (cnt == LAST) begin
        active <= 1'b0;
        cnt    <= '0;
      end else begin
        shreg <= {shreg[ADDR_W-2:0], evt.sda};
        cnt   <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/altaddr_flag_ctrl.sv
module altaddr_flag_ctrl #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_evt,
  input  logic              frame_done,
  input  logic [ADDR_W-1:0] addr_bits,
  input  logic [ADDR_W-1:0] alt_addr,
  input  logic              alt_fmt_sel,
  input  logic              is_master,
  input  logic              is_transmit,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic              reg_wdata,
  output logic              flag,
  output logic              match_pulse
);
  logic armed;   // a read returned 1 and no write followed yet
  logic set_evt, sw_clr;

  assign set_evt = frame_done & (addr_bits == alt_addr) &
                   ~is_master & ~is_transmit & ~alt_fmt_sel;
  assign sw_clr  = reg_wr & ~reg_wdata & armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag        <= 1'b0;
      match_pulse <= 1'b0;
      armed       <= 1'b0;
    end else begin
      match_pulse <= set_evt;
      if (is_master)      flag <= 1'b0;
      else if (start_evt) flag <= 1'b0;
      else if (set_evt)   flag <= 1'b1;   // set beats software clear
      else if (sw_clr)    flag <= 1'b0;

      if (reg_wr)              armed <= 1'b0;
      else if (reg_rd && flag) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/i2c_altaddr_match.sv
module i2c_altaddr_match
  import i2c_altaddr_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              is_master,
  input  logic              is_transmit,
  input  logic [ADDR_W-1:0] alt_addr,
  input  logic              alt_fmt_sel,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic              reg_wdata,
  output logic              flag,
  output logic              match_pulse
);
  logic [1:0]        bus_s;
  bus_evt_t          bus_evt;
  logic              start_evt;
  logic              frame_done;
  logic [ADDR_W-1:0] addr_bits;

  altaddr_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(bus_s)
  );

  altaddr_bus_events u_evt (
    .clk(clk), .rst_n(rst_n), .scl_s(bus_s[1]), .sda_s(bus_s[0]), .evt(bus_evt)
  );

  assign start_evt = bus_evt.start;

  altaddr_frame_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .evt(bus_evt),
    .frame_done(frame_done), .addr_bits(addr_bits)
  );

  altaddr_flag_ctrl #(.ADDR_W(ADDR_W)) u_flag (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt),
    .frame_done(frame_done), .addr_bits(addr_bits),
    .alt_addr(alt_addr), .alt_fmt_sel(alt_fmt_sel),
    .is_master(is_master), .is_transmit(is_transmit),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .flag(flag), .match_pulse(match_pulse)
  );
endmodule

// File: rtl/i2c_altaddr_match_chk.sv
module i2c_altaddr_match_chk (
  input logic clk,
  input logic rst_n,
  input logic start_evt,
  input logic is_master,
  input logic is_transmit,
  input logic alt_fmt_sel,
  input logic reg_wr,
  input logic reg_wdata,
  input logic flag,
  input logic match_pulse
);
  // R1: the flag only rises together with a match pulse
  a_r1_rise_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> match_pulse);

  // R1: the pulse lasts one cycle
  a_r1_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |=> !match_pulse);

  // R7: after a set event the flag is 1, whatever software wrote
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> flag);

  // R2: no set with format select high
  a_r2_fmt_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> $past(!alt_fmt_sel));

  // R9: no set in transmit mode
  a_r9_tx_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> $past(!is_transmit));

  // R3: START clears
  a_r3_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !flag);

  // R4: master mode clears and holds
  a_r4_master_clears: assert property (@(posedge clk) disable iff (!rst_n)
    is_master |=> !flag);

  // R6: a write of 1 never clears
  a_r6_write_one_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && reg_wr && reg_wdata && !is_master && !start_evt) |=> flag);
endmodule

bind i2c_altaddr_match i2c_altaddr_match_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_evt(start_evt),
  .is_master(is_master), .is_transmit(is_transmit),
  .alt_fmt_sel(alt_fmt_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .flag(flag), .match_pulse(match_pulse)
);

// File: tb/i2c_altaddr_match_bench.sv
`timescale 1ns/1ps
module i2c_altaddr_match_bench;
  localparam int H = 4;  // clocks per SCL half period

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_raw = 1'b1, sda_raw = 1'b1;
  logic is_master = 1'b0, is_transmit = 1'b0, alt_fmt_sel = 1'b0;
  logic [6:0] alt_addr = 7'h5A;
  logic reg_rd = 1'b0, reg_wr = 1'b0, reg_wdata = 1'b0;
  logic flag, match_pulse;

  int n_chk = 0, n_fail = 0, cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  i2c_altaddr_match u_i2c_altaddr_match (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_raw), .sda_in(sda_raw),
    .is_master(is_master), .is_transmit(is_transmit),
    .alt_addr(alt_addr), .alt_fmt_sel(alt_fmt_sel),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .flag(flag), .match_pulse(match_pulse)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit hs[$], hd[$];
  bit m_flag, m_pulse, m_armed, m_in;
  int m_cnt, m_val;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      hs = '{1'b1, 1'b1, 1'b1};
      hd = '{1'b1, 1'b1, 1'b1};
      m_flag = 0; m_pulse = 0; m_armed = 0; m_in = 0; m_cnt = 0; m_val = 0;
    end else begin
      bit cs, ps, cd, pd, st, rise, setev, old_f;
      hs.push_back(scl_raw);
      hd.push_back(sda_raw);
      if (hs.size() > 8) begin
        void'(hs.pop_front());
        void'(hd.pop_front());
      end
      cs = hs[hs.size()-3]; ps = hs[hs.size()-4];
      cd = hd[hd.size()-3]; pd = hd[hd.size()-4];
      st = cs && ps && pd && !cd;
      rise = cs && !ps;
      setev = 0;
      if (st) begin
        m_in = 1; m_cnt = 0; m_val = 0;
      end else if (rise && m_in) begin
        m_val = m_val * 2 + int'(cd);
        m_cnt++;
        if (m_cnt == 8) begin
          m_in = 0;
          if ((m_val >> 1) == int'(alt_addr) && !is_master && !is_transmit && !alt_fmt_sel)
            setev = 1;
        end
      end
      old_f = m_flag;
      if (is_master) m_flag = 0;
      else if (st) m_flag = 0;
      else if (setev) m_flag = 1;
      else if (reg_wr && !reg_wdata && m_armed) m_flag = 0;
      if (reg_wr) m_armed = 0;
      else if (reg_rd && old_f) m_armed = 1;
      m_pulse = setev;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(flag == m_flag, "model flag (R1 R3 R4 R5 R7)", int'(flag), int'(m_flag));
      chk(match_pulse == m_pulse, "model pulse (R1 R2 R9)", int'(match_pulse), int'(m_pulse));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_raw = 1'b1; idle(H);
    scl_raw = 1'b1; idle(H);
    sda_raw = 1'b0; idle(H);
    scl_raw = 1'b0; idle(H);
  endtask

  task automatic bus_bit(input bit b);
    sda_raw = b;    idle(H);
    scl_raw = 1'b1; idle(H);
    scl_raw = 1'b0; idle(H);
  endtask

  task automatic bus_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) bus_bit(v[i]);
  endtask

  task automatic reg_read();
    reg_rd = 1'b1; idle(1);
    reg_rd = 1'b0; idle(1);
  endtask

  task automatic reg_write(input bit v);
    reg_wr = 1'b1; reg_wdata = v; idle(1);
    reg_wr = 1'b0; reg_wdata = 1'b0; idle(2);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    wait (cycles > 100000);
    if (!done) begin
      done = 1'b1;
      chk(1'b0, "watchdog", cycles, 100000);
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- directed sequence ----------------
  initial begin
    idle(5);
    chk(flag == 1'b0, "R10 reset flag", int'(flag), 0);
    chk(match_pulse == 1'b0, "R10 reset pulse", int'(match_pulse), 0);
    rst_n = 1'b1;
    idle(5);

    // R1: match with write direction
    bus_start(); bus_byte({7'h5A, 1'b0}); idle(4);
    chk(flag == 1'b1, "R1 match sets flag", int'(flag), 1);

    // R6: write 1, and write 0 without a prior read
    reg_write(1'b1);
    chk(flag == 1'b1, "R6 write 1 ignored", int'(flag), 1);
    reg_write(1'b0);
    chk(flag == 1'b1, "R6 write 0 without read ignored", int'(flag), 1);

    // R5: read then write 0
    reg_read(); reg_write(1'b0);
    chk(flag == 1'b0, "R5 read then write 0 clears", int'(flag), 0);

    // R1: read/write bit ignored in comparison
    bus_start(); bus_byte({7'h5A, 1'b1}); idle(4);
    chk(flag == 1'b1, "R1 rw bit ignored", int'(flag), 1);

    // R8: second byte without START does not set
    reg_read(); reg_write(1'b0);
    bus_byte({7'h5A, 1'b0}); idle(4);
    chk(flag == 1'b0, "R8 second byte ignored", int'(flag), 0);

    // R3: START clears a set flag
    bus_start(); bus_byte({7'h5A, 1'b0}); idle(4);
    bus_start();
    chk(flag == 1'b0, "R3 start clears", int'(flag), 0);

    // R1: mismatch
    bus_byte({7'h5B, 1'b0}); idle(4);
    chk(flag == 1'b0, "R1 mismatch no set", int'(flag), 0);

    // R2: format select blocks
    alt_fmt_sel = 1'b1;
    bus_start(); bus_byte({7'h5A, 1'b0}); idle(4);
    chk(flag == 1'b0, "R2 format select blocks", int'(flag), 0);
    alt_fmt_sel = 1'b0;

    // R9: transmit mode blocks
    is_transmit = 1'b1;
    bus_start(); bus_byte({7'h5A, 1'b0}); idle(4);
    chk(flag == 1'b0, "R9 transmit blocks", int'(flag), 0);
    is_transmit = 1'b0;

    // R4: master mode clears and blocks
    alt_addr = 7'h13;
    bus_start(); bus_byte({7'h13, 1'b0}); idle(4);
    chk(flag == 1'b1, "R1 new address sets", int'(flag), 1);
    is_master = 1'b1; idle(2);
    chk(flag == 1'b0, "R4 master clears", int'(flag), 0);
    bus_start(); bus_byte({7'h13, 1'b0}); idle(4);
    chk(flag == 1'b0, "R4 master blocks set", int'(flag), 0);
    is_master = 1'b0;

    // R3: repeated START mid-byte restarts capture
    bus_start(); bus_bit(1'b1); bus_bit(1'b0); bus_bit(1'b1);
    bus_start(); bus_byte({7'h13, 1'b0}); idle(4);
    chk(flag == 1'b1, "R3 restart mid-byte then match", int'(flag), 1);

    // R7: arm with a read, then write 0 in the exact set cycle
    reg_read();
    bus_start();
    for (int i = 6; i >= 0; i--) bus_bit(alt_addr[i]);
    sda_raw = 1'b0; idle(H);
    scl_raw = 1'b1;           // sampled at edge e
    idle(1);                  // after edge e
    idle(1);                  // after edge e+1
    reg_wr = 1'b1; reg_wdata = 1'b0;
    idle(1);                  // after edge e+2: set edge
    reg_wr = 1'b0;
    chk(match_pulse == 1'b1, "R7 pulse in set cycle", int'(match_pulse), 1);
    chk(flag == 1'b1, "R7 set wins over clear", int'(flag), 1);
    idle(H); scl_raw = 1'b0; idle(H);
    reg_read(); reg_write(1'b0);
    chk(flag == 1'b0, "R5 clear after handshake", int'(flag), 0);

    idle(10);
    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule